// File: doc/BRIEF.md
# Loopback I/O Self-Test Engine

This block is a built-in tester for a board whose I/O pins are wired back to themselves through a passive fixture. A strap input, which the fixture pulls low, enables the test. With the strap low after reset, the engine runs by itself and needs no host. It drives a bank of output pins with a fixed series of stimulus words. For each word it compares the looped-back input bank with the value it drove, and it collects the mismatching bits.

When the series ends, one of two LEDs shows the overall verdict. While the test runs, a serial transmit line sends one text record for each stimulus word. That record names the failing pin positions for that word, so a technician can find a bad solder joint or a bent pin without probing the board. In normal use the strap floats high and the engine stays silent.

The controller has five states:
- `ST_IDLE`: waiting for the strap.
- `ST_DRIVE`: holding the current word for the settle window.
- `ST_SAMPLE`: comparing the inputs.
- `ST_SEND`: emitting the record bytes.
- `ST_DONE`: showing the verdict.

It moves between them through these transitions:
- *start*: `ST_IDLE` to `ST_DRIVE` when the strap is seen low.
- *settled*: `ST_DRIVE` to `ST_SAMPLE` when the hold count expires.
- *compared*: `ST_SAMPLE` to `ST_SEND`.
- *next*: `ST_SEND` to `ST_DRIVE` after the last byte of a record that is not the final one.
- *finish*: `ST_SEND` to `ST_DONE` after the final record.
- *abort*: any of `ST_DRIVE`, `ST_SAMPLE` or `ST_SEND` back to `ST_IDLE` when the strap is seen high.

Top module: `loopback_selftest`

## Requirements
- R1: While the synchronized strap is high and no test is running, `pin_oe` is 0, `pin_out` is all zeros, both LEDs are off and `uart_tx` stays at 1.
- R2: When `strap_n` is low after reset, the test starts without any other input and visits the stimulus indices 0 to 2*W+3 in ascending order, one word for each index.
- R3: The stimulus word for each index is as follows:
  - Index 0 is all zeros and index 1 is all ones.
  - Index 2+j (j from 0 to W-1) has only bit j set.
  - Index W+2+j has only bit j clear.
  - Index 2*W+2 has every even-numbered bit set, so bit 0 is 1.
  - Index 2*W+3 is the bitwise inverse of index 2*W+2.
- R4: Each word is driven for SETTLE cycles, and `pin_in` passes through a two-flop synchronizer. The per-word mismatch mask is the synchronized input XOR the driven word, sampled at the end of that window.
- R5: A failure mask ORs in every per-word mismatch. In `ST_DONE`, `led_pass` is 1 only if this mask is zero; otherwise `led_fail` is 1. Exactly one LED is lit in `ST_DONE`.
- R6: In `ST_DONE` the pins are released (`pin_oe` = 0), and the LEDs keep their values whatever the strap and the inputs do until the next reset.
- R7: Each serial byte is 8N1, with the least significant bit first. Every bit, including the start and stop bits, lasts BAUD_DIV clocks, and the line idles at 1.
- R8: Each record is NHEX+5 bytes, with NHEX = ceil(W/4). The bytes are, in order:
  - two uppercase ASCII hex digits of the index;
  - `=`;
  - NHEX hex digits of that word's mismatch mask, most significant first;
  - `P` if that mask is zero, else `F`;
  - a line feed (0x0A).
- R9: If the strap is seen high while a test is running, the engine returns to `ST_IDLE`. It releases the pins, clears the failure mask and silences the serial line. A later low strap restarts the series from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_n | input | 1 | Test-enable strap, active low |
| pin_in | input | W | Looped-back pin values |
| pin_out | output | W | Stimulus word |
| pin_oe | output | 1 | Output enable for `pin_out` |
| led_pass | output | 1 | Overall pass indicator |
| led_fail | output | 1 | Overall fail indicator |
| uart_tx | output | 1 | Serial report line |

## Verification
The hardest situations to reach are a fault that shows up in only a few stimulus words and an abort in the middle of a record. The bench models the fixture with a stuck-at-0 or stuck-at-1 fault on each pin position in turn. For every word it predicts arithmetically which records must show which mask, and it decodes every byte on the serial line. For the abort case, the bench raises the strap partway through a faulty run. It then checks that the line goes quiet, and it reruns with the fault removed; a clean pass on that rerun shows the failure mask was cleared.

// File: rtl/lst_pkg.sv
package lst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_SAMPLE,
        ST_SEND,
        ST_DONE
    } lst_state_e;

    function automatic logic [7:0] hex_char(input logic [3:0] nib);
        return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
    endfunction

endpackage

// File: rtl/lst_sync.sv
module lst_sync #(
    parameter int   W    = 1,
    parameter logic INIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= {W{INIT}};
            q    <= {W{INIT}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lst_uart_tx.sv
module lst_uart_tx #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       start,
    input  logic [7:0] data,
    output logic       ready,
    output logic       tx
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [9:0]    frame;
    logic [3:0]    bitn;
    logic [DW-1:0] divc;
    logic          busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame <= '1;
            bitn  <= '0;
            divc  <= '0;
            busy  <= 1'b0;
        end else if (flush) begin
            frame <= '1;
            bitn  <= '0;
            divc  <= '0;
            busy  <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                frame <= {1'b1, data, 1'b0};
                bitn  <= '0;
                divc  <= '0;
                busy  <= 1'b1;
            end
        end else if (divc == DW'(DIV - 1)) begin
            divc  <= '0;
            frame <= {1'b1, frame[9:1]};
            bitn  <= bitn + 4'd1;
            if (bitn == 4'd9) busy <= 1'b0;
        end else begin
            divc <= divc + DW'(1);
        end
    end

    assign ready = !busy;
    assign tx    = frame[0];

    // R7: an accepted byte opens with a low start bit on the next cycle
    a_r7_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && !flush) |=> (tx == 1'b0));
    // R7: the line is high whenever no byte is in flight
    a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> tx);
endmodule

// File: rtl/lst_record.sv
module lst_record #(
    parameter int W = 16
) (
    input  logic [7:0]                          idx,
    input  logic [W-1:0]                        mask,
    input  logic [$clog2(((W + 3) / 4) + 5)-1:0] pos,
    output logic [7:0]                          ch
);
    import lst_pkg::*;

    localparam int NHEX = (W + 3) / 4;
    localparam int NREC = NHEX + 5;
    localparam int POSW = $clog2(NREC);

    logic [4*NHEX-1:0] padded;

    always_comb begin
        padded         = '0;
        padded[W-1:0]  = mask;
        ch             = 8'h0A;
        if (pos == POSW'(0))      ch = hex_char(idx[7:4]);
        else if (pos == POSW'(1)) ch = hex_char(idx[3:0]);
        else if (pos == POSW'(2)) ch = 8'h3D;
        else if (pos == POSW'(NHEX + 3)) ch = (|mask) ? 8'h46 : 8'h50;
        for (int j = 0; j < NHEX; j++) begin
            if (pos == POSW'(3 + j)) ch = hex_char(padded[4*(NHEX-1-j) +: 4]);
        end
    end
endmodule

// File: rtl/loopback_selftest.sv
module loopback_selftest #(
    parameter int W        = 16,
    parameter int SETTLE   = 8,
    parameter int BAUD_DIV = 434
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic         pin_oe,
    output logic         led_pass,
    output logic         led_fail,
    output logic         uart_tx
);
    import lst_pkg::*;

    localparam int NPAT = 2 * W + 4;
    localparam int IDXW = 8;
    localparam int NHEX = (W + 3) / 4;
    localparam int NREC = NHEX + 5;
    localparam int POSW = $clog2(NREC);
    localparam int CW   = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    lst_state_e      state, nxt;
    logic [IDXW-1:0] idx;
    logic [CW-1:0]   cnt;
    logic [POSW-1:0] pos;
    logic [W-1:0]    cur_mask, fail_mask, pin_s, expected;
    logic [0:0]      strap_q;
    logic            strap_s, testing, tx_ready, tx_start, tx_flush;
    logic            last_byte, last_pat;
    logic [7:0]      rec_byte;

    lst_sync #(.W(W), .INIT(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

    lst_sync #(.W(1), .INIT(1'b1)) u_strap_sync (
        .clk(clk), .rst_n(rst_n), .d(strap_n), .q(strap_q));

    assign strap_s = strap_q[0];

    function automatic logic [W-1:0] pattern_of(input logic [IDXW-1:0] k);
        logic [W-1:0] one, p;
        one = {{(W-1){1'b0}}, 1'b1};
        if (k == IDXW'(0))              p = '0;
        else if (k == IDXW'(1))         p = '1;
        else if (k < IDXW'(W + 2))      p = one << (k - IDXW'(2));
        else if (k < IDXW'(2 * W + 2))  p = ~(one << (k - IDXW'(W + 2)));
        else begin
            for (int b = 0; b < W; b++) p[b] = ~b[0];
            if (k == IDXW'(2 * W + 3)) p = ~p;
        end
        return p;
    endfunction

    assign expected  = pattern_of(idx);
    assign last_byte = (pos == POSW'(NREC - 1));
    assign last_pat  = (idx == IDXW'(NPAT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!strap_s) nxt = ST_DRIVE;
            ST_DRIVE:  if (cnt == CW'(SETTLE - 1)) nxt = ST_SAMPLE;
            ST_SAMPLE: nxt = ST_SEND;
            ST_SEND:   if (tx_ready && last_byte) nxt = last_pat ? ST_DONE : ST_DRIVE;
            ST_DONE:   nxt = ST_DONE;
            default:   nxt = ST_IDLE;
        endcase
        if (strap_s && testing) nxt = ST_IDLE;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            cnt       <= '0;
            pos       <= '0;
            cur_mask  <= '0;
            fail_mask <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx       <= '0;
                    cnt       <= '0;
                    pos       <= '0;
                    cur_mask  <= '0;
                    fail_mask <= '0;
                end
                ST_DRIVE:  cnt <= cnt + CW'(1);
                ST_SAMPLE: begin
                    cur_mask  <= pin_s ^ expected;
                    fail_mask <= fail_mask | (pin_s ^ expected);
                    cnt       <= '0;
                    pos       <= '0;
                end
                ST_SEND: if (tx_ready) begin
                    if (last_byte) begin
                        pos <= '0;
                        if (!last_pat) idx <= idx + IDXW'(1);
                    end else begin
                        pos <= pos + POSW'(1);
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        testing  = (state == ST_DRIVE) || (state == ST_SAMPLE) || (state == ST_SEND);
        pin_oe   = testing;
        pin_out  = testing ? expected : '0;
        led_pass = (state == ST_DONE) && (fail_mask == '0);
        led_fail = (state == ST_DONE) && (fail_mask != '0);
        tx_start = (state == ST_SEND);
        tx_flush = (state == ST_IDLE);
    end

    lst_record #(.W(W)) u_record (
        .idx(idx), .mask(cur_mask), .pos(pos), .ch(rec_byte));

    lst_uart_tx #(.DIV(BAUD_DIV)) u_uart (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .start(tx_start),
        .data(rec_byte), .ready(tx_ready), .tx(uart_tx));

    // R1: idle with strap high keeps pins released and the line high
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!pin_oe && pin_out == '0 && uart_tx));
    // R4: comparison only follows a full settle window
    a_r4_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE) |-> ($past(state) == ST_DRIVE && $past(cnt) == CW'(SETTLE - 1)));
    // R5: exactly one LED lit once the run is over
    a_r5_one_led: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> $onehot({led_pass, led_fail}));
    // R6: verdict holds in DONE
    a_r6_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_DONE && $stable(fail_mask) && !pin_oe));
    // R9: strap high during a run aborts
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_s && testing) |=> (state == ST_IDLE));
    // R2: index never leaves the stimulus range
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDXW'(NPAT - 1));
endmodule

// File: tb/test_loopback_selftest.sv
module test_loopback_selftest;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int SET  = 4;
    localparam int DIV  = 2;
    localparam int NPAT = 2 * W + 4;
    localparam int NREC = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strap_n = 1'b1;
    logic [W-1:0] pin_in, pin_out;
    logic         pin_oe, led_pass, led_fail, uart_tx;
    logic [W-1:0] s0 = '0, s1 = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0] seen [0:31];
    int           nseen = 0;
    bit           seen_clr = 1'b0;
    logic         p_oe = 1'b0;
    logic [W-1:0] p_out = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // passive fixture with stuck-at faults
    assign pin_in = pin_oe ? ((pin_out & ~s0) | s1) : '0;

    loopback_selftest #(.W(W), .SETTLE(SET), .BAUD_DIV(DIV)) i_loopback_selftest (
        .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .led_pass(led_pass),
        .led_fail(led_fail), .uart_tx(uart_tx));

    always @(negedge clk) begin
        if (seen_clr) nseen = 0;
        else if (pin_oe && (!p_oe || pin_out != p_out)) begin
            if (nseen < 32) seen[nseen] = pin_out;
            nseen++;
        end
        p_oe  = pin_oe;
        p_out = pin_out;
    end

    function automatic logic [W-1:0] pat(input int k);
        logic [W-1:0] p;
        if (k == 0) p = '0;
        else if (k == 1) p = '1;
        else if (k < W + 2) p = W'(1) << (k - 2);
        else if (k < 2 * W + 2) p = ~(W'(1) << (k - W - 2));
        else begin
            p = 8'h55;
            if (k == 2 * W + 3) p = ~p;
        end
        return p;
    endfunction

    function automatic logic [W-1:0] emask(input int k);
        return ((pat(k) & ~s0) | s1) ^ pat(k);
    endfunction

    function automatic logic [7:0] hexc(input logic [3:0] n);
        return (n < 10) ? 8'h30 + {4'h0, n} : 8'h37 + {4'h0, n};
    endfunction

    function automatic logic [7:0] rec(input int k, input int b, input logic [7:0] m);
        logic [7:0] kk;
        kk = 8'(k);
        case (b)
            0: return hexc(kk[7:4]);
            1: return hexc(kk[3:0]);
            2: return 8'h3D;
            3: return hexc(m[7:4]);
            4: return hexc(m[3:0]);
            5: return (m != 0) ? 8'h46 : 8'h50;
            default: return 8'h0A;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        seen_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        seen_clr = 1'b0;
    endtask

    task automatic recv(output logic [7:0] d, output bit ok);
        wait (uart_tx === 1'b0);
        @(posedge clk); #1;
        ok = (uart_tx == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (DIV) @(posedge clk); #1;
            d[i] = uart_tx;
        end
        repeat (DIV) @(posedge clk); #1;
        ok = ok && (uart_tx == 1'b1);
    endtask

    task automatic run_full(input bit chk_seq);
        logic [7:0] got, m, all;
        bit         fr;
        all = '0;
        for (int k = 0; k < NPAT; k++) begin
            m = emask(k);
            all |= m;
            for (int b = 0; b < NREC; b++) begin
                recv(got, fr);
                check(fr, "R7", "frame start/stop", 32'(fr), 32'd1);
                if (b == 3 || b == 4)
                    check(got == rec(k, b, m), "R4", "mask digit", 32'(got), 32'(rec(k, b, m)));
                else
                    check(got == rec(k, b, m), "R8", "record byte", 32'(got), 32'(rec(k, b, m)));
            end
        end
        repeat (3) @(posedge clk); #1;
        check(led_pass == (all == 0) && led_fail == (all != 0), "R5", "leds",
              {30'd0, led_pass, led_fail}, {30'd0, all == 0, all != 0});
        check(!pin_oe, "R6", "pins released", 32'(pin_oe), 32'd0);
        check(nseen == NPAT, "R2", "words visited", 32'(nseen), 32'(NPAT));
        if (chk_seq)
            for (int k = 0; k < NPAT; k++)
                check(seen[k] == pat(k), "R3", "stimulus word", 32'(seen[k]), 32'(pat(k)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int bad;
        // reset state, strap inactive (R1)
        do_reset();
        #1;
        check(!pin_oe && pin_out == 0 && uart_tx && !led_pass && !led_fail, "R1", "reset outputs",
              {pin_out, 4'd0, 1'b0, pin_oe, uart_tx, led_pass}, 32'h2);
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pin_oe || pin_out != 0 || !uart_tx || led_pass || led_fail) bad++;
        end
        check(bad == 0, "R1", "quiet while strap high", 32'(bad), 32'd0);

        // R2: strap low starts without reset; clean fixture passes
        strap_n = 1'b0;
        run_full(1'b1);

        // R6: verdict latched regardless of strap and inputs
        strap_n = 1'b1;
        s0 = '1;
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!led_pass || led_fail || pin_oe) bad++;
        end
        check(bad == 0, "R6", "latched verdict", 32'(bad), 32'd0);
        s0 = '0;

        // sweep of single stuck-at faults (R4, R5, R8)
        for (int b = 0; b < W; b++) begin
            for (int pol = 0; pol < 2; pol++) begin
                strap_n = 1'b0;
                s0 = (pol == 0) ? W'(1) << b : '0;
                s1 = (pol == 1) ? W'(1) << b : '0;
                do_reset();
                run_full(b == 0);
            end
        end
        s0 = '0;
        s1 = '0;

        // R9: abort mid-run, then rerun cleanly
        s1 = 8'h01;
        strap_n = 1'b0;
        do_reset();
        repeat (600) @(posedge clk);
        strap_n = 1'b1;
        repeat (5) @(posedge clk); #1;
        check(!pin_oe && pin_out == 0, "R9", "pins released on abort",
              {23'd0, pin_oe, pin_out}, 32'd0);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!uart_tx || led_pass || led_fail) bad++;
        end
        check(bad == 0, "R9", "line silent after abort", 32'(bad), 32'd0);
        s1 = '0;
        seen_clr = 1'b1;
        @(negedge clk);
        seen_clr = 1'b0;
        strap_n = 1'b0;
        run_full(1'b1);
        check(led_pass, "R9", "mask cleared by abort", 32'(led_pass), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule